// File: doc/BRIEF.md
# Per-Channel Video Gain Scaler

This block scales three 10-bit component video channels (G/Y, R/Cr, B/Cb) by independent digital gains on their way to the output converters. A channel whose input uses only part of the code range can be stretched to fill the converter. The same gains trim small mismatches between channels, so that luma and chroma reach one common full-scale level and white balance can be set. The result is carried as an 11-bit code, one bit finer than the input.

Each channel has an 11-bit unsigned gain. The gain is a fraction in which code 1024 means unity and 2047 means just under 2.0. Gains are loaded through a one-cycle register write port. A gain belongs to the sample that is accepted on the same clock edge, so a sample is never computed with a mix of old and new settings. Samples come in with a valid strobe and leave two clocks later with a matching strobe. A result that would exceed the 11-bit range is held at full scale, and a sticky per-channel flag records the event until software clears it. A bypass setting skips the multiplication and only widens each code by one bit.

Top module: `video_gain_scaler`

## Requirements
- R1: While reset is held and after it is released with no activity, out_valid is 0, every bit of out_data is 0 and ovf_flag is 0. All gains start at 1024 and bypass starts off, so a first sample of code N gives 2N on every channel.
- R2: out_valid is in_valid delayed by exactly two clock cycles, and the result of each accepted sample appears on the cycle its delayed strobe is high.
- R3: Channel c takes in_data[10c+9:10c] and drives out_data[11c+10:11c], where c=0 is G/Y, c=1 is R/Cr and c=2 is B/Cb. Its result is floor((x*g + 256) / 512), where g is the 11-bit gain of that channel. Writing cfg_addr=c loads g from cfg_wdata[10:0], and each channel's gain is independent of the others.
- R4: A result above 2047 is output as 2047 and never wraps.
- R5: Bit c of ovf_flag goes high on the cycle channel c outputs a clamped result, and it stays high until a write to cfg_addr=4 with cfg_wdata bit c set. Clear bits that are 0 leave their flags unchanged.
- R6: A gain write on the same clock edge as, or after, the edge that accepts a sample does not change that sample's result. The new gain applies to samples accepted on later edges.
- R7: Writing cfg_addr=3 with cfg_wdata bit 0 set turns on bypass, and writing it with that bit clear turns bypass off. In bypass every channel outputs its input shifted left by one bit, with the same two-cycle latency, and no flag is set.
- R8: While out_valid is low, out_data keeps the last result.
- R9: Writes to cfg_addr 5, 6 and 7 change neither the gains, the bypass setting nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 3 | Register address: 0 to 2 gains, 3 bypass, 4 flag clear |
| cfg_wdata | input | 11 | Register write data |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 30 | Three 10-bit input codes, channel 0 in the low bits |
| out_valid | output | 1 | Output sample strobe, two cycles after in_valid |
| out_data | output | 33 | Three 11-bit scaled codes, channel 0 in the low bits |
| ovf_flag | output | 3 | Sticky saturation flag per channel |

## Verification
A corrupted gain or bypass register shows up on the very next sample: the channel's code changes from the value the formula predicts, and the error stays until the register is rewritten. A slip in the valid pipeline or in the capture of the gain shows up within two cycles. Either out_valid rises on the wrong edge, or a sample that is in flight during a gain write comes out with the new gain. A bad flag shows up as soon as the flag drops without a clear, as a clear bit hitting its neighbour, or as a flag that rises on a cycle whose output is below 2047.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  localparam int DATA_W     = 10;
  localparam int GAIN_W     = 11;
  localparam int OUT_W      = 11;
  localparam int FRAC_SHIFT = 9;
  localparam int NUM_CH     = 3;
  localparam int ADDR_W     = 3;

  localparam logic [ADDR_W-1:0] ADDR_BYPASS  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_OVF_CLR = 3'd4;

  // gain code that multiplies by exactly 2^(OUT_W-DATA_W)
  localparam int unsigned GAIN_UNITY = 2 ** (FRAC_SHIFT + OUT_W - DATA_W);
endpackage

// File: rtl/vgs_rst_sync.sv
module vgs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/vgs_cfg_regs.sv
module vgs_cfg_regs
  import vgs_pkg::*;
#(
  parameter int NCH   = NUM_CH,
  parameter int GW    = GAIN_W,
  parameter int AW    = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [GW-1:0]     cfg_wdata,
  input  logic [NCH-1:0]    sat_set,
  output logic [NCH*GW-1:0] gain_flat,
  output logic              bypass,
  output logic [NCH-1:0]    ovf_flag
);
  localparam logic [GW-1:0] UNITY = GW'(GAIN_UNITY);

  // gain registers, one per channel
  for (genvar c = 0; c < NCH; c++) begin : g_gain
    logic          hit;
    logic [GW-1:0] gain_d;
    logic [GW-1:0] gain_q;

    always_comb begin
      hit    = cfg_we && (cfg_addr == AW'(c));
      gain_d = hit ? cfg_wdata : gain_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_q <= UNITY;
      end else begin
        gain_q <= gain_d;
      end
    end

    assign gain_flat[c*GW +: GW] = gain_q;
  end

  // bypass control
  logic byp_d;
  logic byp_q;

  always_comb begin
    byp_d = byp_q;
    if (cfg_we && (cfg_addr == ADDR_BYPASS)) begin
      byp_d = cfg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else begin
      byp_q <= byp_d;
    end
  end

  assign bypass = byp_q;

  // sticky flags: a set in the same cycle as a clear wins
  logic [NCH-1:0] clr_mask;
  logic [NCH-1:0] ovf_d;
  logic [NCH-1:0] ovf_q;

  always_comb begin
    clr_mask = '0;
    if (cfg_we && (cfg_addr == ADDR_OVF_CLR)) begin
      clr_mask = cfg_wdata[NCH-1:0];
    end
    ovf_d = (ovf_q & ~clr_mask) | sat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign ovf_flag = ovf_q;
endmodule

// File: rtl/vgs_lane.sv
module vgs_lane #(
  parameter int DW     = 10,
  parameter int GW     = 11,
  parameter int OW     = 11,
  parameter int FSHIFT = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          upd_en,
  input  logic          byp_in,
  input  logic [DW-1:0] x_in,
  input  logic [GW-1:0] gain_in,
  output logic [OW-1:0] y_out,
  output logic          sat_set
);
  localparam int PROD_W = DW + GW;
  localparam int WIDEN  = OW - DW;
  localparam logic [PROD_W:0] RND_K = {{PROD_W{1'b0}}, 1'b1} << (FSHIFT - 1);

  // stage 1: sample together with the gain and mode that belong to it
  logic [DW-1:0] x_d,   x_q;
  logic [GW-1:0] g_d,   g_q;
  logic          byp_d, byp_q;

  always_comb begin
    x_d   = cap_en ? x_in    : x_q;
    g_d   = cap_en ? gain_in : g_q;
    byp_d = cap_en ? byp_in  : byp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      g_q   <= '0;
      byp_q <= 1'b0;
    end else begin
      x_q   <= x_d;
      g_q   <= g_d;
      byp_q <= byp_d;
    end
  end

  // stage 2: multiply, round to nearest, saturate
  logic [PROD_W-1:0] prod;
  logic [PROD_W:0]   rnd;
  logic [PROD_W:0]   quo;
  logic              over;
  logic [OW-1:0]     scaled;
  logic [OW-1:0]     widened;
  logic [OW-1:0]     y_d, y_q;

  always_comb begin
    prod    = PROD_W'(x_q) * PROD_W'(g_q);
    rnd     = {1'b0, prod} + RND_K;
    quo     = rnd >> FSHIFT;
    over    = |quo[PROD_W:OW];
    scaled  = over ? {OW{1'b1}} : quo[OW-1:0];
    widened = {x_q, {WIDEN{1'b0}}};
    y_d     = upd_en ? (byp_q ? widened : scaled) : y_q;
    sat_set = upd_en && !byp_q && over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
    end else begin
      y_q <= y_d;
    end
  end

  assign y_out = y_q;
endmodule

// File: rtl/video_gain_scaler.sv
module video_gain_scaler
  import vgs_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int GW  = GAIN_W,
  parameter int OW  = OUT_W,
  parameter int AW  = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [GW-1:0]     cfg_wdata,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_data,
  output logic              out_valid,
  output logic [NCH*OW-1:0] out_data,
  output logic [NCH-1:0]    ovf_flag
);
  logic              rst_n_int;
  logic [NCH*GW-1:0] gain_flat;
  logic              bypass;
  logic [NCH-1:0]    sat_set;

  vgs_rst_sync u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_sync(rst_n_int)
  );

  vgs_cfg_regs #(.NCH(NCH), .GW(GW), .AW(AW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .sat_set  (sat_set),
    .gain_flat(gain_flat),
    .bypass   (bypass),
    .ovf_flag (ovf_flag)
  );

  // valid pipeline, matched to the two data stages
  logic v1_d, v1_q, v2_d, v2_q;

  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  assign out_valid = v2_q;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    vgs_lane #(.DW(DW), .GW(GW), .OW(OW), .FSHIFT(FRAC_SHIFT)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .cap_en (in_valid),
      .upd_en (v1_q),
      .byp_in (bypass),
      .x_in   (in_data[c*DW +: DW]),
      .gain_in(gain_flat[c*GW +: GW]),
      .y_out  (out_data[c*OW +: OW]),
      .sat_set(sat_set[c])
    );
  end
endmodule

// File: rtl/video_gain_scaler_checker.sv
module video_gain_scaler_checker
  import vgs_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int GW  = GAIN_W,
  parameter int OW  = OUT_W,
  parameter int AW  = ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [AW-1:0]     cfg_addr,
  input logic [GW-1:0]     cfg_wdata,
  input logic              in_valid,
  input logic [NCH*DW-1:0] in_data,
  input logic              out_valid,
  input logic [NCH*OW-1:0] out_data,
  input logic [NCH-1:0]    ovf_flag
);
  logic dly1_q, dly2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly1_q <= 1'b0;
      dly2_q <= 1'b0;
    end else begin
      dly1_q <= in_valid;
      dly2_q <= dly1_q;
    end
  end

  // R2
  assert_two_cycle_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == dly2_q);

  // R8
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R5
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[c] && !(cfg_we && cfg_addr == ADDR_OVF_CLR && cfg_wdata[c]))
      |=> ovf_flag[c]);

    // R4
    assert_flag_means_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag[c]) |-> (out_valid && out_data[c*OW +: OW] == {OW{1'b1}}));
  end
endmodule

bind video_gain_scaler video_gain_scaler_checker #(
  .NCH(NCH), .DW(DW), .GW(GW), .OW(OW), .AW(AW)
) u_checker (.*);

// File: tb/video_gain_scaler_test.sv
module video_gain_scaler_test;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [10:0] cfg_wdata;
  logic        in_valid;
  logic [29:0] in_data;
  logic        out_valid;
  logic [32:0] out_data;
  logic [2:0]  ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  video_gain_scaler uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .ovf_flag(ovf_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // each vector, fields ordered channel 2, 1, 0: gains, inputs, expected codes
  typedef struct packed {
    logic [2:0][10:0] g;
    logic [2:0][9:0]  x;
    logic [2:0][10:0] e;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    {11'd1024, 11'd1024, 11'd1024, 10'd1023, 10'd512, 10'd0,    11'd2046, 11'd1024, 11'd0},
    {11'd1024, 11'd1024, 11'd1024, 10'd960,  10'd940, 10'd64,   11'd1920, 11'd1880, 11'd128},
    {11'd1091, 11'd1091, 11'd1115, 10'd960,  10'd960, 10'd940,  11'd2046, 11'd2046, 11'd2047},
    {11'd2047, 11'd1,    11'd0,    10'd1,    10'd1023, 10'd1023, 11'd4,   11'd2,    11'd0},
    {11'd511,  11'd513,  11'd512,  10'd3,    10'd101, 10'd100,  11'd3,    11'd101,  11'd100},
    {11'd768,  11'd255,  11'd256,  10'd1,    10'd1,   10'd1,    11'd2,    11'd0,    11'd1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [10:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // leaves the bench at the negedge where the result must be visible
  task automatic sample(input logic [9:0] a2, input logic [9:0] a1, input logic [9:0] a0);
    @(negedge clk);
    in_valid = 1'b1; in_data = {a2, a1, a0};
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "valid one cycle after accept", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R2", "valid two cycles after accept", {31'd0, out_valid}, 32'd1);
  endtask

  function automatic logic [31:0] lane(input int c);
    return {21'd0, out_data[c*11 +: 11]};
  endfunction

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1", "out_data in reset", {31'd0, |out_data}, 32'd0);
    chk("R1", "flags in reset", {29'd0, ovf_flag}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "out_valid after release", {31'd0, out_valid}, 32'd0);

    // R1: unity gains after reset
    sample(10'd30, 10'd20, 10'd10);
    chk("R1", "unity ch0", lane(0), 32'd20);
    chk("R1", "unity ch1", lane(1), 32'd40);
    chk("R1", "unity ch2", lane(2), 32'd60);

    // R3: table of gains and inputs
    for (int i = 0; i < NV; i++) begin
      for (int c = 0; c < 3; c++) wr(3'(c), VECS[i].g[c]);
      sample(VECS[i].x[2], VECS[i].x[1], VECS[i].x[0]);
      for (int c = 0; c < 3; c++) chk("R3", $sformatf("vector %0d ch%0d", i, c), lane(c), {21'd0, VECS[i].e[c]});
      @(negedge clk);
      // R8: hold while idle
      chk("R8", $sformatf("idle after vector %0d", i), {31'd0, out_valid}, 32'd0);
      for (int c = 0; c < 3; c++) chk("R8", $sformatf("hold ch%0d", c), lane(c), {21'd0, VECS[i].e[c]});
    end
    chk("R5", "no flag without clamp", {29'd0, ovf_flag}, 32'd0);

    // R4 and R5: saturation and sticky flags
    for (int c = 0; c < 3; c++) wr(3'(c), 11'd2047);
    sample(10'd0, 10'd600, 10'd1023);
    chk("R4", "clamp ch0", lane(0), 32'd2047);
    chk("R4", "clamp no wrap ch1", lane(1), 32'd2047);
    chk("R4", "zero ch2", lane(2), 32'd0);
    chk("R5", "flags set", {29'd0, ovf_flag}, 32'd3);
    repeat (3) @(negedge clk);
    chk("R5", "flags sticky", {29'd0, ovf_flag}, 32'd3);
    wr(3'd4, 11'd4);
    chk("R5", "clear of unset bit", {29'd0, ovf_flag}, 32'd3);
    wr(3'd4, 11'd1);
    chk("R5", "clear bit 0", {29'd0, ovf_flag}, 32'd2);
    wr(3'd4, 11'd2);
    chk("R5", "clear bit 1", {29'd0, ovf_flag}, 32'd0);

    // R7: bypass
    wr(3'd3, 11'd1);
    sample(10'd0, 10'd5, 10'd1023);
    chk("R7", "bypass ch0", lane(0), 32'd2046);
    chk("R7", "bypass ch1", lane(1), 32'd10);
    chk("R7", "bypass ch2", lane(2), 32'd0);
    chk("R7", "no flag in bypass", {29'd0, ovf_flag}, 32'd0);
    wr(3'd3, 11'd0);
    sample(10'd0, 10'd0, 10'd1);
    chk("R7", "bypass off", lane(0), 32'd4);

    // R6: gain changes at sample boundaries only
    wr(3'd0, 11'd1024);
    @(negedge clk);
    in_valid = 1'b1; in_data = {10'd0, 10'd0, 10'd100};
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 11'd512;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R6", "write while in flight", lane(0), 32'd200);
    @(negedge clk);
    in_valid = 1'b1; in_data = {10'd0, 10'd0, 10'd100};
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 11'd256;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    chk("R6", "write on accept edge", lane(0), 32'd100);
    sample(10'd0, 10'd0, 10'd100);
    chk("R6", "new gain applied", lane(0), 32'd50);

    // R9: unused addresses
    for (int c = 0; c < 3; c++) wr(3'(c), 11'd1024);
    wr(3'd5, 11'd0);
    wr(3'd6, 11'd1);
    wr(3'd7, 11'd0);
    sample(10'd7, 10'd8, 10'd9);
    chk("R9", "ch0 unchanged", lane(0), 32'd18);
    chk("R9", "ch1 unchanged", lane(1), 32'd16);
    chk("R9", "ch2 unchanged", lane(2), 32'd14);
    chk("R9", "flags unchanged", {29'd0, ovf_flag}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R2): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule